// File: doc/BRIEF.md
# Host FIFO Register Window

This block gives a host bus access to four FIFOs that sit between the host and a MAC: outgoing data, incoming data, outgoing status and incoming status. The host side is a simple single-cycle select/write-enable bus with byte addresses and 32-bit words. Read data is registered and returned one cycle after the access, together with a valid strobe. The MAC side has a valid/ready handshake per FIFO. The MAC pops the outgoing data FIFO and pushes into the other three.

Each data FIFO answers at eight consecutive word addresses, all with the same behaviour. A host can therefore run an incrementing-address burst and still stream through one FIFO. Each status FIFO has two read locations. One removes the oldest entry. The other only looks at the oldest entry and leaves it in place. Two more registers expose the fill levels, the full/empty state and sticky error flags. A write of ones to the error flags clears them.

Top module: `host_fifo_window`

## Requirements
- R1: After reset all four FIFOs are empty, `host_rvalid_o` and `txd_valid_o` are 0, all three MAC ready outputs are 1, and the flag register reads 0x0000_5500.
- R2: A host write to any word address 00h, 04h, … 1Ch pushes `host_wdata_i` into the outgoing data FIFO. The MAC receives these words on `txd_data_o` in write order.
- R3: A host read of any word address 20h, 24h, … 3Ch pops the incoming data FIFO. The word comes back on `host_rdata_o` in the next cycle, with `host_rvalid_o` high for that one cycle. Reads return the words in MAC push order.
- R4: A host read of 40h pops the incoming status FIFO, and a read of 48h pops the outgoing status FIFO. Each returns the oldest entry.
- R5: A host read of 44h returns the oldest incoming status entry without removing it, and 4Ch does the same for the outgoing status FIFO. Repeated peeks with no pop in between return the same value.
- R6: A host write to the outgoing data window while that FIFO is full is dropped and sets sticky flag bit 0.
- R7: A host pop of an empty FIFO returns zero and sets a sticky flag bit: bit 1 for incoming data, bit 2 for incoming status, bit 3 for outgoing status.
- R8: A read of 50h returns the levels as four byte fields: [7:0] outgoing data, [15:8] incoming data, [23:16] incoming status, [31:24] outgoing status.
- R9: A read of 54h returns the sticky bits in [3:0] and the live state in [15:8]. Bit 8 is outgoing-data empty and bit 9 its full. Bits 10 and 11 are incoming-data empty and full, bits 12 and 13 incoming-status empty and full, bits 14 and 15 outgoing-status empty and full. Writing 54h clears every sticky bit whose `host_wdata_i` bit is 1.
- R10: Reads of undecoded addresses, and reads of the outgoing data window, return zero and change no state. Writes to any address other than 00h–1Ch and 54h have no effect.
- R11: Each MAC ready output is high exactly when its FIFO is not full. `txd_valid_o` is high exactly when the outgoing data FIFO is not empty, and `txd_data_o` then shows its oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_sel_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | 1 write, 0 read |
| host_addr_i | input | ADDR_W | Byte address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Registered read data |
| host_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| txd_valid_o | output | 1 | Outgoing data word available |
| txd_data_o | output | DATA_W | Oldest outgoing data word |
| txd_ready_i | input | 1 | MAC takes outgoing data word |
| rxd_valid_i | input | 1 | MAC offers incoming data word |
| rxd_data_i | input | DATA_W | Incoming data word |
| rxd_ready_o | output | 1 | Incoming data FIFO not full |
| rxs_valid_i | input | 1 | MAC offers incoming status word |
| rxs_data_i | input | DATA_W | Incoming status word |
| rxs_ready_o | output | 1 | Incoming status FIFO not full |
| txs_valid_i | input | 1 | MAC offers outgoing status word |
| txs_data_i | input | DATA_W | Outgoing status word |
| txs_ready_o | output | 1 | Outgoing status FIFO not full |

## Verification
The hardest case to reach is a host access and a MAC handshake landing on the same FIFO in the same cycle while it is at a boundary. Examples are a host push while the MAC pops a full outgoing FIFO, or a host pop of an incoming FIFO that holds one word while the MAC pushes. Directed phases fill each FIFO to full and drain it past empty. A long phase then throws random host accesses over every decoded and some undecoded addresses, together with random MAC valid and ready. The queue model in the bench is compared against every output on every clock.

// File: rtl/hfw_pkg.sv
package hfw_pkg;
  // word-index map (byte address >> 2)
  localparam int unsigned W_TXD_BASE = 0;
  localparam int unsigned W_RXD_BASE = 8;
  localparam int unsigned W_ALIASES  = 8;
  localparam int unsigned W_RXS_POP  = 16;
  localparam int unsigned W_RXS_PEEK = 17;
  localparam int unsigned W_TXS_POP  = 18;
  localparam int unsigned W_TXS_PEEK = 19;
  localparam int unsigned W_LEVELS   = 20;
  localparam int unsigned W_FLAGS    = 21;

  localparam int unsigned LVL_FW = 8;

  typedef enum logic [3:0] {
    RG_NONE, RG_TXD, RG_RXD, RG_RXS_POP, RG_RXS_PEEK,
    RG_TXS_POP, RG_TXS_PEEK, RG_LEVELS, RG_FLAGS
  } hfw_region_e;
endpackage

// File: rtl/hfw_fifo.sv
module hfw_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/hfw_addr_dec.sv
module hfw_addr_dec
  import hfw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hfw_region_e       region_o
);
  logic [31:0] widx;
  assign widx = 32'(addr_i[ADDR_W-1:2]);

  always_comb begin
    region_o = RG_NONE;
    if (widx < W_TXD_BASE + W_ALIASES)                              region_o = RG_TXD;
    else if (widx >= W_RXD_BASE && widx < W_RXD_BASE + W_ALIASES)   region_o = RG_RXD;
    else if (widx == W_RXS_POP)                                     region_o = RG_RXS_POP;
    else if (widx == W_RXS_PEEK)                                    region_o = RG_RXS_PEEK;
    else if (widx == W_TXS_POP)                                     region_o = RG_TXS_POP;
    else if (widx == W_TXS_PEEK)                                    region_o = RG_TXS_PEEK;
    else if (widx == W_LEVELS)                                      region_o = RG_LEVELS;
    else if (widx == W_FLAGS)                                       region_o = RG_FLAGS;
  end
endmodule

// File: rtl/host_fifo_window.sv
module host_fifo_window
  import hfw_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned TXD_DEPTH = 16,
  parameter int unsigned RXD_DEPTH = 16,
  parameter int unsigned RXS_DEPTH = 8,
  parameter int unsigned TXS_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_sel_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_rvalid_o,
  output logic              txd_valid_o,
  output logic [DATA_W-1:0] txd_data_o,
  input  logic              txd_ready_i,
  input  logic              rxd_valid_i,
  input  logic [DATA_W-1:0] rxd_data_i,
  output logic              rxd_ready_o,
  input  logic              rxs_valid_i,
  input  logic [DATA_W-1:0] rxs_data_i,
  output logic              rxs_ready_o,
  input  logic              txs_valid_i,
  input  logic [DATA_W-1:0] txs_data_i,
  output logic              txs_ready_o
);
  localparam int unsigned TXD_CW = $clog2(TXD_DEPTH + 1);
  localparam int unsigned RXD_CW = $clog2(RXD_DEPTH + 1);
  localparam int unsigned RXS_CW = $clog2(RXS_DEPTH + 1);
  localparam int unsigned TXS_CW = $clog2(TXS_DEPTH + 1);

  hfw_region_e region;
  logic acc_rd, acc_wr;

  logic [DATA_W-1:0] txd_head, rxd_head, rxs_head, txs_head;
  logic txd_full, txd_empty, rxd_full, rxd_empty;
  logic rxs_full, rxs_empty, txs_full, txs_empty;
  logic [TXD_CW-1:0] txd_cnt;
  logic [RXD_CW-1:0] rxd_cnt;
  logic [RXS_CW-1:0] rxs_cnt;
  logic [TXS_CW-1:0] txs_cnt;

  logic host_txd_push, host_rxd_pop, host_rxs_pop, host_txs_pop;
  logic [3:0] sticky_q, sticky_set;
  logic [DATA_W-1:0] rd_mux, levels_word, flags_word;
  logic [DATA_W-1:0] rdata_q;
  logic rvalid_q;

  hfw_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr_i(host_addr_i), .region_o(region));

  assign acc_rd = host_sel_i & ~host_we_i;
  assign acc_wr = host_sel_i & host_we_i;

  assign host_txd_push = acc_wr & (region == RG_TXD);
  assign host_rxd_pop  = acc_rd & (region == RG_RXD);
  assign host_rxs_pop  = acc_rd & (region == RG_RXS_POP);
  assign host_txs_pop  = acc_rd & (region == RG_TXS_POP);

  hfw_fifo #(.DW(DATA_W), .DEPTH(TXD_DEPTH)) u_txd (
    .clk_i, .rst_ni, .push_i(host_txd_push), .wdata_i(host_wdata_i),
    .pop_i(txd_ready_i), .rdata_o(txd_head), .full_o(txd_full),
    .empty_o(txd_empty), .cnt_o(txd_cnt));

  hfw_fifo #(.DW(DATA_W), .DEPTH(RXD_DEPTH)) u_rxd (
    .clk_i, .rst_ni, .push_i(rxd_valid_i), .wdata_i(rxd_data_i),
    .pop_i(host_rxd_pop), .rdata_o(rxd_head), .full_o(rxd_full),
    .empty_o(rxd_empty), .cnt_o(rxd_cnt));

  hfw_fifo #(.DW(DATA_W), .DEPTH(RXS_DEPTH)) u_rxs (
    .clk_i, .rst_ni, .push_i(rxs_valid_i), .wdata_i(rxs_data_i),
    .pop_i(host_rxs_pop), .rdata_o(rxs_head), .full_o(rxs_full),
    .empty_o(rxs_empty), .cnt_o(rxs_cnt));

  hfw_fifo #(.DW(DATA_W), .DEPTH(TXS_DEPTH)) u_txs (
    .clk_i, .rst_ni, .push_i(txs_valid_i), .wdata_i(txs_data_i),
    .pop_i(host_txs_pop), .rdata_o(txs_head), .full_o(txs_full),
    .empty_o(txs_empty), .cnt_o(txs_cnt));

  assign txd_valid_o = ~txd_empty;
  assign txd_data_o  = txd_head;
  assign rxd_ready_o = ~rxd_full;
  assign rxs_ready_o = ~rxs_full;
  assign txs_ready_o = ~txs_full;

  assign levels_word = DATA_W'({LVL_FW'(txs_cnt), LVL_FW'(rxs_cnt),
                                LVL_FW'(rxd_cnt), LVL_FW'(txd_cnt)});
  assign flags_word  = DATA_W'({txs_full, txs_empty, rxs_full, rxs_empty,
                                rxd_full, rxd_empty, txd_full, txd_empty,
                                4'b0000, sticky_q});

  always_comb begin
    unique case (region)
      RG_RXD:      rd_mux = rxd_empty ? '0 : rxd_head;
      RG_RXS_POP,
      RG_RXS_PEEK: rd_mux = rxs_empty ? '0 : rxs_head;
      RG_TXS_POP,
      RG_TXS_PEEK: rd_mux = txs_empty ? '0 : txs_head;
      RG_LEVELS:   rd_mux = levels_word;
      RG_FLAGS:    rd_mux = flags_word;
      default:     rd_mux = '0;
    endcase
  end

  assign sticky_set = {host_txs_pop & txs_empty, host_rxs_pop & rxs_empty,
                       host_rxd_pop & rxd_empty, host_txd_push & txd_full};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= acc_rd;
      if (acc_rd) rdata_q <= rd_mux;
      if (acc_wr && region == RG_FLAGS) sticky_q <= sticky_q & ~host_wdata_i[3:0];
      else                              sticky_q <= sticky_q | sticky_set;
    end
  end

  assign host_rdata_o  = rdata_q;
  assign host_rvalid_o = rvalid_q;
endmodule

// File: rtl/hfw_chk.sv
module hfw_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned RXD_DEPTH = 16,
  parameter int unsigned TXD_CW    = 5,
  parameter int unsigned RXD_CW    = 5,
  parameter int unsigned RXS_CW    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_sel_i,
  input logic              host_we_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [DATA_W-1:0] host_wdata_i,
  input logic              host_rvalid_o,
  input logic              rxd_ready_o,
  input logic [TXD_CW-1:0] txd_cnt,
  input logic [RXD_CW-1:0] rxd_cnt,
  input logic [RXS_CW-1:0] rxs_cnt,
  input logic [3:0]        sticky_q
);
  logic rd, clr_ovr;
  assign rd      = host_sel_i && !host_we_i;
  assign clr_ovr = host_sel_i && host_we_i && (host_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(21))
                   && host_wdata_i[0];

  a_r3_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> host_rvalid_o);

  a_r3_no_stray_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !host_rvalid_o);

  a_r5_peek_keeps_entries: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && host_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(17)) |=> (int'(rxs_cnt) >= int'($past(rxs_cnt))));

  a_r2_txd_level_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(txd_cnt) - int'($past(txd_cnt)) <= 1) && (int'($past(txd_cnt)) - int'(txd_cnt) <= 1));

  a_r6_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_q[0] && !clr_ovr) |=> sticky_q[0]);

  a_r11_rxd_ready_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxd_ready_o == (int'(rxd_cnt) != int'(RXD_DEPTH)));
endmodule

bind host_fifo_window hfw_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RXD_DEPTH(RXD_DEPTH),
  .TXD_CW(TXD_CW), .RXD_CW(RXD_CW), .RXS_CW(RXS_CW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_sel_i(host_sel_i), .host_we_i(host_we_i),
  .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i), .host_rvalid_o(host_rvalid_o),
  .rxd_ready_o(rxd_ready_o), .txd_cnt(txd_cnt), .rxd_cnt(rxd_cnt), .rxs_cnt(rxs_cnt),
  .sticky_q(sticky_q)
);

// File: tb/tb_host_fifo_window.sv
module tb_host_fifo_window;
  localparam int TXD = 16, RXD = 16, RSD = 8, TSD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, we = 0, txd_ready = 0, rxd_valid = 0, rxs_valid = 0, txs_valid = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rxd_data = '0, rxs_data = '0, txs_data = '0;
  logic [31:0] rdata, txd_data;
  logic rvalid, txd_valid, rxd_ready, rxs_ready, txs_ready;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] txq[$], rxq[$], rsq[$], tsq[$];
  logic [3:0]  m_sticky;
  logic        m_rvalid;
  logic [31:0] m_rdata;
  string       m_tag;

  always #10 clk = ~clk;

  host_fifo_window dut (
    .clk_i(clk), .rst_ni(rst_n), .host_sel_i(sel), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .host_rvalid_o(rvalid),
    .txd_valid_o(txd_valid), .txd_data_o(txd_data), .txd_ready_i(txd_ready),
    .rxd_valid_i(rxd_valid), .rxd_data_i(rxd_data), .rxd_ready_o(rxd_ready),
    .rxs_valid_i(rxs_valid), .rxs_data_i(rxs_data), .rxs_ready_o(rxs_ready),
    .txs_valid_i(txs_valid), .txs_data_i(txs_data), .txs_ready_o(txs_ready));

  // behavioural reference, updated at every active edge
  always @(posedge clk or negedge rst_n) begin : model
    int ntx, nrx, nrs, nts, w;
    logic [31:0] rv, lvl, flg;
    logic push_tx;
    if (!rst_n) begin
      txq.delete(); rxq.delete(); rsq.delete(); tsq.delete();
      m_sticky = '0; m_rvalid = 0; m_rdata = '0; m_tag = "R1";
    end else begin
      ntx = txq.size(); nrx = rxq.size(); nrs = rsq.size(); nts = tsq.size();
      w = int'(addr[7:2]);
      push_tx = 0;
      lvl = {8'(nts), 8'(nrs), 8'(nrx), 8'(ntx)};
      flg = {16'b0, nts == TSD, nts == 0, nrs == RSD, nrs == 0,
             nrx == RXD, nrx == 0, ntx == TXD, ntx == 0, 4'b0, m_sticky};
      m_rvalid = sel && !we;
      if (sel && !we) begin
        rv = '0; m_tag = "R10";
        if (w >= 8 && w < 16) begin
          if (nrx > 0) begin rv = rxq.pop_front(); m_tag = "R3"; end
          else begin m_sticky[1] = 1; m_tag = "R7"; end
        end else if (w == 16) begin
          if (nrs > 0) begin rv = rsq.pop_front(); m_tag = "R4"; end
          else begin m_sticky[2] = 1; m_tag = "R7"; end
        end else if (w == 18) begin
          if (nts > 0) begin rv = tsq.pop_front(); m_tag = "R4"; end
          else begin m_sticky[3] = 1; m_tag = "R7"; end
        end else if (w == 17) begin
          rv = (nrs > 0) ? rsq[0] : '0; m_tag = "R5";
        end else if (w == 19) begin
          rv = (nts > 0) ? tsq[0] : '0; m_tag = "R5";
        end else if (w == 20) begin
          rv = lvl; m_tag = "R8";
        end else if (w == 21) begin
          rv = flg; m_tag = "R9";
        end
        m_rdata = rv;
      end
      if (sel && we) begin
        if (w < 8) begin
          if (ntx < TXD) push_tx = 1; else m_sticky[0] = 1;
        end else if (w == 21) m_sticky = m_sticky & ~wdata[3:0];
      end
      if (txd_ready && ntx > 0) void'(txq.pop_front());
      if (push_tx) txq.push_back(wdata);
      if (rxd_valid && nrx < RXD) rxq.push_back(rxd_data);
      if (rxs_valid && nrs < RSD) rsq.push_back(rxs_data);
      if (txs_valid && nts < TSD) tsq.push_back(txs_data);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3 rvalid", 32'(rvalid), 32'(m_rvalid));
      if (m_rvalid) chk(m_tag, rdata, m_rdata);
      chk("R11 txd_valid", 32'(txd_valid), 32'(txq.size() > 0));
      if (txq.size() > 0) chk("R2 txd_data", txd_data, txq[0]);
      chk("R11 rxd_ready", 32'(rxd_ready), 32'(rxq.size() < RXD));
      chk("R11 rxs_ready", 32'(rxs_ready), 32'(rsq.size() < RSD));
      chk("R11 txs_ready", 32'(txs_ready), 32'(tsq.size() < TSD));
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic hop(input logic w, input logic [7:0] a, input logic [31:0] d);
    sel = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd_valid", 32'(txd_valid), 0);
    chk("R1 rvalid", 32'(rvalid), 0);
    hop(0, 8'h54, 0);                               // R1 / R9 expect 0x5500
    chk("R1 flags", rdata, 32'h0000_5500);
    // R2 aliases, then fill and overrun (R6)
    for (int i = 0; i < 8; i++) hop(1, 8'(i * 4), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 10; i++) hop(1, 8'(4 * (i % 8)), 32'hB000_0000 + 32'(i));
    hop(0, 8'h54, 0);                               // R6 sticky bit 0, R9 full bit
    hop(0, 8'h50, 0);                               // R8 level
    hop(1, 8'h54, 32'h1);                           // R9 clear
    hop(0, 8'h54, 0);
    txd_ready = 1; idle(6);
    for (int i = 0; i < 6; i++) hop(1, 8'h1C, 32'hC000_0000 + 32'(i));
    idle(20); txd_ready = 0;
    // R3 alias pops, R7 underrun
    rxd_valid = 1;
    for (int i = 0; i < 5; i++) begin rxd_data = 32'hD000_0000 + 32'(i); @(negedge clk); end
    rxd_valid = 0;
    for (int i = 0; i < 7; i++) hop(0, 8'h20 + 8'(i * 4), 0);
    // status FIFOs: R5 peek, R4 pop, R7 underrun
    rxs_valid = 1; txs_valid = 1;
    for (int i = 0; i < 3; i++) begin
      rxs_data = 32'hE000_0000 + 32'(i); txs_data = 32'hF000_0000 + 32'(i); @(negedge clk);
    end
    rxs_valid = 0; txs_valid = 0;
    hop(0, 8'h44, 0); hop(0, 8'h44, 0); hop(0, 8'h4C, 0); hop(0, 8'h4C, 0);
    for (int i = 0; i < 4; i++) begin hop(0, 8'h40, 0); hop(0, 8'h48, 0); end
    hop(0, 8'h44, 0); hop(0, 8'h54, 0);
    // R10 undecoded and ignored accesses
    hop(1, 8'h60, 32'hFFFF_FFFF); hop(1, 8'h24, 32'h1234_5678); hop(1, 8'h40, 32'h1);
    hop(0, 8'h60, 0); hop(0, 8'h04, 0); hop(0, 8'h50, 0); hop(0, 8'hFC, 0);
    hop(1, 8'h54, 32'hF); hop(0, 8'h54, 0);
    // R11 fill all MAC-side FIFOs to full
    rxd_valid = 1; rxs_valid = 1; txs_valid = 1;
    for (int i = 0; i < 20; i++) begin
      rxd_data = 32'(i) * 3; rxs_data = 32'(i) * 5; txs_data = 32'(i) * 7; @(negedge clk);
    end
    hop(0, 8'h3C, 0); hop(0, 8'h50, 0); hop(0, 8'h54, 0);
    rxd_valid = 0; rxs_valid = 0; txs_valid = 0;
    // random mix at every boundary
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ra;
      ra = 8'(($urandom % 24) * 4);
      rxd_valid = 1'($urandom); rxs_valid = 1'($urandom % 3 == 0);
      txs_valid = 1'($urandom % 3 == 0); txd_ready = 1'($urandom % 3 == 0);
      rxd_data = $urandom; rxs_data = $urandom; txs_data = $urandom;
      if ($urandom % 4 != 0) hop(1'($urandom % 2), ra, $urandom);
      else @(negedge clk);
    end
    rxd_valid = 0; rxs_valid = 0; txs_valid = 0; txd_ready = 0;
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule